// File: doc/BRIEF.md
# Ping-Pong Acquisition Buffer Sequencer

This block collects a stream of sample words into two equal buffers and fills them one after the other. When the filling buffer is full, the block raises a transfer request to an external DMA engine. The request carries the buffer's index, base address and length. Sampling moves on to the other buffer with no gap. The DMA engine drains the full buffer through a synchronous read port. It then returns a one-cycle done pulse, and only after that pulse can the block raise its next request.

If the filling buffer is full while the earlier transfer is still outstanding, the block does not overwrite anything. It holds the full buffer, sets a sticky overflow flag and counts the samples it has to drop. A chained mode groups N consecutive buffers under one long transfer command. A one-cycle pulse marks the first request of the group, and a second pulse marks the done that completes it. A start pulse arms acquisition and clears all state. A stop pulse ends acquisition and hands over the partly filled buffer with its actual length.

The buffer depth is a parameter counted in words. A 512 KiB buffer of 32-bit words needs a depth of 131072. The default is kept small so the block elaborates quickly.

Top module: `pingpong_seq`

## Requirements
- R1: After reset, and until the first start pulse, `req_valid`, `fill_buf`, `fill_level`, `overflow`, `proto_err`, `done_count` and `drop_count` are all 0, and incoming samples are not accepted.
- R2: Buffers fill in strict alternation, starting with buffer 0 after start. The edge that accepts the DEPTH-th sample raises `req_valid` with `req_buf` set to the buffer that was just filled, `req_base` set to BASE0 (buffer 0) or BASE1 (buffer 1), and `req_len` set to DEPTH. At the same edge `fill_buf` switches and `fill_level` returns to 0.
- R3: While `req_valid` is high, `req_buf`, `req_base` and `req_len` do not change. A `xfer_done` pulse during a request drops `req_valid` at the next edge and adds 1 to `done_count`.
- R4: When `rd_en` is high, `rd_data` returns one cycle later the word at offset `rd_addr` in the buffer named by `req_buf`. Offsets count samples in arrival order, starting at 0.
- R5: While a request is outstanding, samples keep filling the other buffer, and `fill_level` reports how many words that buffer holds.
- R6: If a buffer fills while a request is outstanding, `overflow` is set and stays set until start. The full buffer is held with `fill_level` equal to DEPTH, and later samples are dropped and counted in `drop_count`. The buffer under transfer is not modified. The done pulse requests the held buffer at the same edge.
- R7: A `xfer_done` pulse with no request outstanding has no effect on the request or on `done_count`, and it sets the sticky `proto_err` flag.
- R8: A stop pulse ends acquisition, and the sample offered in the stop cycle is also ignored. A non-empty filling buffer is requested with `req_len` equal to its fill level, immediately if no request is outstanding and otherwise after the next done. An empty buffer produces no request.
- R9: A start pulse clears `overflow`, `proto_err`, `done_count`, `drop_count`, `fill_level` and any outstanding request, and filling restarts in buffer 0.
- R10: `chain_len` is captured at start, with 0 treated as 1. `cmd_start` pulses for one cycle with the first request of each group of `chain_len` buffers. `cmd_done` pulses for one cycle after the done that completes a group, or after the done of a transfer that stop shortened.
- R11: If a done pulse arrives in the same cycle as a buffer fills, the new request is raised at that edge and `overflow` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse: clear state and begin acquisition |
| stop | input | 1 | Pulse: end acquisition and hand over the partial buffer |
| chain_len | input | CH_W | Buffers per transfer command, captured at start |
| in_valid | input | 1 | Sample strobe |
| in_data | input | DATA_W | Sample word |
| req_valid | output | 1 | Transfer request outstanding (busy) |
| req_buf | output | 1 | Index of the buffer to transfer |
| req_base | output | ADDR_W | Base address of that buffer |
| req_len | output | LVL_W | Words to transfer |
| xfer_done | input | 1 | One-cycle done pulse from the DMA engine |
| cmd_start | output | 1 | Pulse: a new transfer command begins |
| cmd_done | output | 1 | Pulse: the transfer command has completed |
| rd_en | input | 1 | Read strobe from the DMA engine |
| rd_addr | input | IDX_W | Word offset within the requested buffer |
| rd_data | output | DATA_W | Read word, one cycle after `rd_en` |
| fill_buf | output | 1 | Index of the buffer being filled |
| fill_level | output | LVL_W | Words in the filling buffer |
| done_count | output | CNT_W | Number of completed transfers |
| overflow | output | 1 | Sticky overflow flag |
| drop_count | output | CNT_W | Number of dropped samples |
| proto_err | output | 1 | Sticky flag: done arrived with no request outstanding |

## Verification
Every status output and request field changes at the clock edge that registers the causing input, so its new value can be read right after that edge. The bench drives inputs just after one rising edge and samples one time unit after the next edge. Read data carries one extra register stage: the bench presents an address, waits one edge, and then compares `rd_data`. The `cmd_start` and `cmd_done` pulses last for the single cycle after their cause, and the bench checks that they are high at that sample and low one edge later.

// File: rtl/pingpong_seq.sv
`timescale 1ns/1ps
module pingpong_seq #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 256,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int CH_W   = 8,
  parameter logic [ADDR_W-1:0] BASE0 = '0,
  parameter logic [ADDR_W-1:0] BASE1 = ADDR_W'(DEPTH * (DATA_W / 8)),
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH),
  localparam int MEM_W = $clog2(2 * DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stop,
  input  logic [CH_W-1:0]   chain_len,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              req_valid,
  output logic              req_buf,
  output logic [ADDR_W-1:0] req_base,
  output logic [LVL_W-1:0]  req_len,
  input  logic              xfer_done,
  output logic              cmd_start,
  output logic              cmd_done,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              fill_buf,
  output logic [LVL_W-1:0]  fill_level,
  output logic [CNT_W-1:0]  done_count,
  output logic              overflow,
  output logic [CNT_W-1:0]  drop_count,
  output logic              proto_err
);

  logic [DATA_W-1:0] mem [2*DEPTH];
  logic              active, held, held_part, req_part;
  logic [LVL_W-1:0]  held_len;
  logic [CH_W-1:0]   chain_n, chain_pos;

  logic              done_ok, slot_free, take, last, flush, want, issue, grp_end;
  logic [LVL_W-1:0]  new_len;
  logic              new_part;
  logic [CH_W-1:0]   pos_nx;
  logic [MEM_W-1:0]  wr_ptr, rd_ptr;

  assign done_ok   = xfer_done & req_valid;
  assign slot_free = ~req_valid | done_ok;
  assign take      = active & in_valid & ~held & ~stop;
  assign last      = take & (fill_level == LVL_W'(DEPTH - 1));
  assign flush     = stop & active & ~held & (fill_level != '0);
  assign want      = held | last | flush;
  assign issue     = want & slot_free;
  assign new_len   = held ? held_len : (last ? LVL_W'(DEPTH) : fill_level);
  assign new_part  = held ? held_part : flush;
  assign grp_end   = done_ok & ((chain_pos == chain_n - CH_W'(1)) | req_part);
  assign pos_nx    = grp_end ? '0 : (done_ok ? chain_pos + CH_W'(1) : chain_pos);
  assign wr_ptr    = (fill_buf ? MEM_W'(DEPTH) : '0) + MEM_W'(fill_level);
  assign rd_ptr    = (req_buf  ? MEM_W'(DEPTH) : '0) + MEM_W'(rd_addr);

  always_ff @(posedge clk) begin
    if (take) mem[wr_ptr] <= in_data;
    if (rd_en) rd_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || start) begin
      active     <= start;
      fill_buf   <= 1'b0;
      fill_level <= '0;
      held       <= 1'b0;
      held_len   <= '0;
      held_part  <= 1'b0;
      req_valid  <= 1'b0;
      req_buf    <= 1'b0;
      req_base   <= '0;
      req_len    <= '0;
      req_part   <= 1'b0;
      overflow   <= 1'b0;
      proto_err  <= 1'b0;
      done_count <= '0;
      drop_count <= '0;
      chain_pos  <= '0;
      cmd_start  <= 1'b0;
      cmd_done   <= 1'b0;
      chain_n    <= (start && chain_len != '0) ? chain_len : CH_W'(1);
    end else begin
      cmd_start <= issue & (pos_nx == '0);
      cmd_done  <= grp_end;
      chain_pos <= pos_nx;
      if (stop) active <= 1'b0;
      if (xfer_done && !req_valid) proto_err <= 1'b1;
      if (active && in_valid && held && !stop) drop_count <= drop_count + CNT_W'(1);
      if (done_ok) begin
        req_valid  <= 1'b0;
        done_count <= done_count + CNT_W'(1);
      end
      if (take) fill_level <= fill_level + LVL_W'(1);
      if (want && !slot_free && !held) begin
        held      <= 1'b1;
        held_len  <= new_len;
        held_part <= flush;
        if (last) overflow <= 1'b1;
      end
      if (issue) begin
        req_valid  <= 1'b1;
        req_buf    <= fill_buf;
        req_base   <= fill_buf ? BASE1 : BASE0;
        req_len    <= new_len;
        req_part   <= new_part;
        fill_buf   <= ~fill_buf;
        fill_level <= '0;
        held       <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pingpong_seq_chk.sv
`timescale 1ns/1ps
module pingpong_seq_chk #(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              xfer_done,
  input logic              req_valid,
  input logic              req_buf,
  input logic [ADDR_W-1:0] req_base,
  input logic [LVL_W-1:0]  req_len,
  input logic              fill_buf,
  input logic [LVL_W-1:0]  fill_level,
  input logic              overflow,
  input logic              proto_err,
  input logic [CNT_W-1:0]  done_count,
  input logic              cmd_done
);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !xfer_done && !start |=> req_valid && $stable(req_buf) && $stable(req_base) && $stable(req_len)); // R3

  AST_DONE_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done && req_valid && !start |=> done_count == $past(done_count) + CNT_W'(1)); // R3

  AST_REQ_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_len != '0 && req_len <= LVL_W'(DEPTH)); // R2

  AST_FILL_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> fill_buf != req_buf); // R5

  AST_LEVEL_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    fill_level <= LVL_W'(DEPTH)); // R6

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !start |=> overflow); // R6

  AST_STRAY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done && !req_valid && !start |=> proto_err && !req_valid && $stable(done_count)); // R7

  AST_CMD_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |-> $past(xfer_done) && $past(req_valid)); // R10

endmodule

bind pingpong_seq pingpong_seq_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_pingpong_seq.sv
`timescale 1ns/1ps
module tb_pingpong_seq;
  localparam int D = 16;
  localparam logic [31:0] B0 = 32'h0000_1000;
  localparam logic [31:0] B1 = 32'h0000_2000;

  logic clk = 0, rst_n = 0, start = 0, stop = 0, in_valid = 0, xfer_done = 0, rd_en = 0;
  logic [7:0]  chain_len = 8'd1;
  logic [31:0] in_data = '0;
  logic [3:0]  rd_addr = '0;
  logic        req_valid, req_buf, cmd_start, cmd_done, fill_buf, overflow, proto_err;
  logic [31:0] req_base, rd_data;
  logic [4:0]  req_len, fill_level;
  logic [15:0] done_count, drop_count;

  pingpong_seq #(.DATA_W(32), .DEPTH(D), .ADDR_W(32), .CNT_W(16), .CH_W(8),
                 .BASE0(B0), .BASE1(B1)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .chain_len(chain_len),
    .in_valid(in_valid), .in_data(in_data), .req_valid(req_valid), .req_buf(req_buf),
    .req_base(req_base), .req_len(req_len), .xfer_done(xfer_done), .cmd_start(cmd_start),
    .cmd_done(cmd_done), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .fill_buf(fill_buf), .fill_level(fill_level), .done_count(done_count),
    .overflow(overflow), .drop_count(drop_count), .proto_err(proto_err));

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cmd_seen = 0;
  logic [31:0] exp_buf [2][D];
  logic [31:0] stream_q [$];

  always @(negedge clk) if (cmd_done) cmd_seen++;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic push(input logic [31:0] d);
    in_valid = 1; in_data = d; tick(); in_valid = 0;
  endtask

  task automatic done_pulse();
    xfer_done = 1; tick(); xfer_done = 0;
  endtask

  task automatic fill(input int b, input int from, input int upto);
    for (int i = from; i < upto; i++) begin
      exp_buf[b][i] = $urandom;
      push(exp_buf[b][i]);
    end
  endtask

  task automatic read_check(input string tag, input int b, input int n);
    for (int i = 0; i < n; i++) begin
      rd_en = 1; rd_addr = 4'(i); tick();
      chk(tag, rd_data, exp_buf[b][i]);
    end
    rd_en = 0;
  endtask

  task automatic pulse_start(input logic [7:0] n);
    chain_len = n; start = 1; tick(); start = 0;
  endtask

  function automatic logic [31:0] base_of(input int b);
    return (b == 0) ? B0 : B1;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20080527));
    repeat (3) tick();
    rst_n = 1; tick();
    chk("R1 req_valid", req_valid, 0);
    chk("R1 fill_buf", fill_buf, 0);
    chk("R1 overflow", overflow, 0);
    chk("R1 proto_err", proto_err, 0);
    chk("R1 done_count", done_count, 0);
    chk("R1 drop_count", drop_count, 0);
    push(32'h1234);
    chk("R1 idle sample ignored", fill_level, 0);

    pulse_start(8'd1);
    fill(0, 0, D - 1);
    chk("R5 level before full", fill_level, D - 1);
    fill(0, D - 1, D);
    chk("R2 req raised", req_valid, 1);
    chk("R2 req_buf", req_buf, 0);
    chk("R2 req_base", req_base, B0);
    chk("R2 req_len", req_len, D);
    chk("R2 fill switched", fill_buf, 1);
    chk("R2 level reset", fill_level, 0);
    chk("R10 cmd_start single", cmd_start, 1);
    fill(1, 0, 5);
    chk("R10 cmd_start pulse", cmd_start, 0);
    chk("R5 fill during xfer", fill_level, 5);
    chk("R3 req_buf held", req_buf, 0);
    chk("R3 req_len held", req_len, D);
    read_check("R4 read buf0", 0, D);
    done_pulse();
    chk("R3 req cleared", req_valid, 0);
    chk("R3 done_count", done_count, 1);
    chk("R10 cmd_done single", cmd_done, 1);
    tick();
    chk("R10 cmd_done pulse", cmd_done, 0);
    done_pulse();
    chk("R7 proto_err", proto_err, 1);
    chk("R7 done_count unchanged", done_count, 1);
    chk("R7 no request", req_valid, 0);
    chk("R7 level unchanged", fill_level, 5);

    fill(1, 5, D);
    chk("R2 req buf1", req_buf, 1);
    chk("R2 base buf1", req_base, B1);
    chk("R2 fill back to 0", fill_buf, 0);
    fill(0, 0, D - 1);
    chk("R6 no early overflow", overflow, 0);
    fill(0, D - 1, D);
    chk("R6 overflow set", overflow, 1);
    chk("R6 level held", fill_level, D);
    chk("R6 transfer kept", req_buf, 1);
    for (int i = 0; i < 3; i++) push($urandom);
    chk("R6 drops counted", drop_count, 3);
    chk("R6 level still full", fill_level, D);
    read_check("R6 buf1 intact", 1, D);
    done_pulse();
    chk("R6 held requested", req_valid, 1);
    chk("R6 held buf", req_buf, 0);
    chk("R6 held base", req_base, B0);
    chk("R6 fill moved", fill_buf, 1);
    chk("R6 fill level", fill_level, 0);
    chk("R6 done_count", done_count, 2);
    chk("R6 sticky", overflow, 1);
    read_check("R6 held data", 0, D);
    done_pulse();

    fill(1, 0, 7);
    stop = 1; in_valid = 1; in_data = 32'hDEAD; tick(); stop = 0; in_valid = 0;
    chk("R8 partial request", req_valid, 1);
    chk("R8 partial buf", req_buf, 1);
    chk("R8 partial len", req_len, 7);
    chk("R8 level cleared", fill_level, 0);
    push(32'h1); push(32'h2);
    chk("R8 ignored after stop", fill_level, 0);
    read_check("R8 partial data", 1, 7);
    done_pulse();
    chk("R10 partial ends cmd", cmd_done, 1);
    chk("R8 done_count", done_count, 4);
    stop = 1; tick(); stop = 0;
    chk("R8 empty no request", req_valid, 0);

    pulse_start(8'd3);
    chk("R9 overflow clr", overflow, 0);
    chk("R9 drop clr", drop_count, 0);
    chk("R9 done clr", done_count, 0);
    chk("R9 proto clr", proto_err, 0);
    chk("R9 fill buf0", fill_buf, 0);
    fill(0, 0, D);
    chk("R10 group start", cmd_start, 1);
    fill(1, 0, D - 1);
    exp_buf[1][D-1] = $urandom;
    in_valid = 1; in_data = exp_buf[1][D-1]; xfer_done = 1; tick();
    in_valid = 0; xfer_done = 0;
    chk("R11 same-cycle req", req_valid, 1);
    chk("R11 req buf1", req_buf, 1);
    chk("R11 no overflow", overflow, 0);
    chk("R11 done_count", done_count, 1);
    chk("R10 no new cmd", cmd_start, 0);
    chk("R10 group open", cmd_done, 0);
    read_check("R11 data", 1, D);
    done_pulse();
    chk("R10 mid group", cmd_done, 0);
    fill(0, 0, D);
    chk("R10 third no cmd", cmd_start, 0);
    done_pulse();
    chk("R10 group done", cmd_done, 1);
    fill(1, 0, D);
    chk("R10 next group", cmd_start, 1);
    done_pulse();
    stop = 1; tick(); stop = 0;

    pulse_start(8'd2);
    tick();
    cmd_seen = 0;
    fork
      begin
        for (int n = 0; n < 20 * D; n++) begin
          logic [31:0] d;
          d = $urandom;
          stream_q.push_back(d);
          in_valid = 1; in_data = d; tick(); in_valid = 0;
          tick(); tick();
        end
      end
      begin
        for (int b = 0; b < 20; b++) begin
          int lat;
          while (!req_valid) tick();
          lat = $urandom % 6;
          repeat (lat) tick();
          chk("R2 random alternation", req_buf, b % 2);
          chk("R2 random base", req_base, base_of(b % 2));
          chk("R2 random len", req_len, D);
          for (int i = 0; i < D; i++) begin
            logic [31:0] e;
            e = stream_q.pop_front();
            rd_en = 1; rd_addr = 4'(i); tick();
            chk("R4 random data", rd_data, e);
          end
          rd_en = 0;
          done_pulse();
        end
      end
    join
    tick();
    chk("R5 random no overflow", overflow, 0);
    chk("R3 random done_count", done_count, 20);
    chk("R10 random groups", cmd_seen, 10);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule